// File: doc/BRIEF.md
# Debug Status Register with Mass-Erase Handshake

This block holds the status word that an external debugger reads through its debug access port. It gathers status from the flash, power and reset controllers into one 32-bit value. Most bits pass through live. Two bits hold state:

- **Mass-erase acknowledge.** This flag follows a handshake with the flash controller, and the erase-enable setting gates it.
- **Low-leakage stop exit.** This flag is sticky. The debugger loses its link while the chip sits in that stop mode, so the flag stays set until the link is back and the debugger has seen it.

The debugger pulses `erase_launch_wr` when it writes the erase-in-progress control bit. It pulses `exit_clr_wr` when it writes 1 to the sticky exit flag. It pulses `rd_strobe` to read. The value seen at that read edge is loaded into `rd_data`, which then holds still until the next read.

Top module: `dbg_status_reg`

## Requirements
- R1: Bit 0 (erase acknowledge) reads 0 after a clock edge where `sys_in_reset` is 1, or where `erase_launch_wr` is 1.
- R2: Bit 0 becomes 1 only on an edge where `flash_erase_started` is 1 and an allowed launch is still pending. A `flash_erase_started` pulse with no pending launch leaves bit 0 at 0.
- R3: A launch made while `mass_erase_en` is 0 never produces an acknowledge, even if `flash_erase_started` pulses afterwards.
- R4: Bit 1 equals `flash_ready`, including while `sys_in_reset` is 1.
- R5: Bit 2 equals `secure_lock`. Bit 3 reads 0 while `sys_in_reset` is 1 and reads 1 otherwise.
- R6: Bit 5 equals `mass_erase_en`. Bit 6 equals `backdoor_en`.
- R7: Bit 7 is 1 when the 3-bit `stop_mode_sel` is 010, 011 or 100. All other codes give 0.
- R8: Bit 8 equals `vlp_run` at the read edge and is not sticky.
- R9: Bit 9 becomes 1 after an edge with `lls_exit` high. It stays 1 after `lls_exit` falls.
- R10: Bit 9 is cleared by an edge with `exit_clr_wr` or `sys_in_reset` high. When `lls_exit` and `exit_clr_wr` are high on the same edge, bit 9 reads 1.
- R11: Bit 4 and bits 31 to 10 always read 0.
- R12: `rd_data` is 0 after `rst`. It loads the status word on each edge where `rd_strobe` is 1 and holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| sys_in_reset | input | 1 | 1 while the system is held in reset |
| erase_launch_wr | input | 1 | Debugger write pulse of the erase-in-progress control bit |
| flash_erase_started | input | 1 | Flash controller pulse: mass erase has begun |
| mass_erase_en | input | 1 | Mass erase is permitted by the enable and security settings |
| flash_ready | input | 1 | Flash initialisation done |
| secure_lock | input | 1 | Chip is secured |
| backdoor_en | input | 1 | Backdoor key access enabled |
| stop_mode_sel | input | 3 | Power-controller stop-mode select field |
| vlp_run | input | 1 | Very-low-power run mode active |
| lls_exit | input | 1 | Pulse on exit from low-leakage stop |
| exit_clr_wr | input | 1 | Debugger write-1 to clear bit 9 |
| rd_strobe | input | 1 | Debugger read strobe |
| rd_data | output | 32 | Registered status word |

## Verification
The bench builds the block with its default parameters: a 32-bit read word and a 3-bit stop-mode field. With these values every one of the eight stop-mode codes can be driven, and the zero upper bits 31 to 10 can be seen at the port. The live bits are walked through a vector table that includes the system-in-reset states. Directed sequences then drive the erase handshake and the sticky flag through their clears, their blocked paths and their same-edge collisions.

// File: rtl/dbg_status_pkg.sv
package dbg_status_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SEL_W    = 3;
  // Bit positions decoded by the debugger
  localparam int unsigned B_ACK    = 0;
  localparam int unsigned B_FRDY   = 1;
  localparam int unsigned B_SEC    = 2;
  localparam int unsigned B_SYSRUN = 3;
  localparam int unsigned B_MEEN   = 5;
  localparam int unsigned B_BDKEY  = 6;
  localparam int unsigned B_LPSTOP = 7;
  localparam int unsigned B_VLP    = 8;
  localparam int unsigned B_LLSX   = 9;
  localparam int unsigned USED_W   = 10;
endpackage

// File: rtl/erase_ack_ctrl.sv
module erase_ack_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sys_in_reset,
  input  logic launch_wr,
  input  logic allowed,
  input  logic started,
  output logic ack
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst || sys_in_reset) begin
      ack     <= 1'b0;
      pending <= 1'b0;
    end else if (launch_wr) begin
      ack     <= 1'b0;
      pending <= allowed;
    end else if (pending && started) begin
      ack     <= 1'b1;
      pending <= 1'b0;
    end
  end

  // R1
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (sys_in_reset || launch_wr) |=> !ack);
  // R2
  ack_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(started));
  // R3
  ack_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (launch_wr && !allowed) |=> !pending);
endmodule

// File: rtl/sticky_exit_flag.sv
module sticky_exit_flag (
  input  logic clk,
  input  logic rst,
  input  logic sys_in_reset,
  input  logic set_evt,
  input  logic clr_wr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_wr || sys_in_reset) flag <= 1'b0;
  end

  // R9
  exit_sets_chk: assert property (@(posedge clk) disable iff (rst)
    set_evt |=> flag);
  // R10
  exit_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_evt && (clr_wr || sys_in_reset)) |=> !flag);
endmodule

// File: rtl/stop_mode_decode.sv
module stop_mode_decode #(
  parameter int unsigned SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  output logic             low_power_stop
);
  localparam logic [SEL_W-1:0] CODE_LO = SEL_W'(2);
  localparam logic [SEL_W-1:0] CODE_HI = SEL_W'(4);

  always_comb low_power_stop = (sel >= CODE_LO) && (sel <= CODE_HI);
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_status_pkg::*;
#(
  parameter int unsigned DATA_W = WORD_W,
  parameter int unsigned STOP_W = SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sys_in_reset,
  input  logic              erase_launch_wr,
  input  logic              flash_erase_started,
  input  logic              mass_erase_en,
  input  logic              flash_ready,
  input  logic              secure_lock,
  input  logic              backdoor_en,
  input  logic [STOP_W-1:0] stop_mode_sel,
  input  logic              vlp_run,
  input  logic              lls_exit,
  input  logic              exit_clr_wr,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rd_data
);
  logic ack, exit_flag, lp_stop;
  logic [DATA_W-1:0] status;

  erase_ack_ctrl u_ack (
    .clk(clk), .rst(rst), .sys_in_reset(sys_in_reset),
    .launch_wr(erase_launch_wr), .allowed(mass_erase_en),
    .started(flash_erase_started), .ack(ack)
  );

  sticky_exit_flag u_exit (
    .clk(clk), .rst(rst), .sys_in_reset(sys_in_reset),
    .set_evt(lls_exit), .clr_wr(exit_clr_wr), .flag(exit_flag)
  );

  stop_mode_decode #(.SEL_W(STOP_W)) u_dec (
    .sel(stop_mode_sel), .low_power_stop(lp_stop)
  );

  always_comb begin
    status           = '0;
    status[B_ACK]    = ack;
    status[B_FRDY]   = flash_ready;
    status[B_SEC]    = secure_lock;
    status[B_SYSRUN] = !sys_in_reset;
    status[B_MEEN]   = mass_erase_en;
    status[B_BDKEY]  = backdoor_en;
    status[B_LPSTOP] = lp_stop;
    status[B_VLP]    = vlp_run;
    status[B_LLSX]   = exit_flag;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_strobe) rd_data <= status;
  end

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_strobe |=> $stable(rd_data));
  // R11
  rd_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data[4] == 1'b0) && (rd_data[DATA_W-1:USED_W] == '0));
endmodule

// File: tb/dbg_status_reg_tb_top.sv
module dbg_status_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_in_reset = 0, erase_launch_wr = 0, flash_erase_started = 0;
  logic mass_erase_en = 0, flash_ready = 0, secure_lock = 0, backdoor_en = 0;
  logic [2:0] stop_mode_sel = 3'd0;
  logic vlp_run = 0, lls_exit = 0, exit_clr_wr = 0, rd_strobe = 0;
  logic [31:0] rd_data;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dbg_status_reg dut_i (
    .clk(clk), .rst(rst), .sys_in_reset(sys_in_reset),
    .erase_launch_wr(erase_launch_wr), .flash_erase_started(flash_erase_started),
    .mass_erase_en(mass_erase_en), .flash_ready(flash_ready),
    .secure_lock(secure_lock), .backdoor_en(backdoor_en),
    .stop_mode_sel(stop_mode_sel), .vlp_run(vlp_run), .lls_exit(lls_exit),
    .exit_clr_wr(exit_clr_wr), .rd_strobe(rd_strobe), .rd_data(rd_data)
  );

  // stim = {ready, secure, in_reset, erase_en, backdoor, vlp, sel[2:0]}
  localparam int NV = 8;
  localparam logic [8:0] STIM [NV] = '{
    9'b000000_000, 9'b101000_010, 9'b010100_011, 9'b000011_100,
    9'b110111_101, 9'b000000_001, 9'b001000_110, 9'b000001_111 };
  localparam logic [31:0] EXPV [NV] = '{
    32'h008, 32'h082, 32'h0AC, 32'h1C8, 32'h16E, 32'h008, 32'h000, 32'h108 };

  task automatic chk(input logic [31:0] exp, input string tag);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, rd_data, exp);
    end
  endtask

  task automatic rd_chk(input logic [31:0] exp, input string tag);
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    chk(exp, tag);
  endtask

  task automatic pulse_launch();
    @(negedge clk) erase_launch_wr = 1;
    @(negedge clk) erase_launch_wr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) flash_erase_started = 1;
    @(negedge clk) flash_erase_started = 0;
  endtask

  task automatic pulse_sysrst();
    @(negedge clk) sys_in_reset = 1;
    @(negedge clk) sys_in_reset = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(32'h0, "R12 reset value");
    @(negedge clk) rst = 0;

    // live-bit table, covers R4 R5 R6 R7 R8 R11
    for (int i = 0; i < NV; i++) begin
      {flash_ready, secure_lock, sys_in_reset, mass_erase_en,
       backdoor_en, vlp_run, stop_mode_sel} = STIM[i];
      rd_chk(EXPV[i], "R4/R5/R6/R7/R8/R11 table");
    end
    {flash_ready, secure_lock, sys_in_reset, mass_erase_en,
     backdoor_en, vlp_run, stop_mode_sel} = 9'b0;

    // R12 hold: inputs change without a strobe
    rd_chk(32'h008, "R12 base");
    @(negedge clk) vlp_run = 1;
    chk(32'h008, "R12 hold after vlp change");
    @(negedge clk) chk(32'h008, "R12 hold second cycle");
    rd_chk(32'h108, "R8 live vlp");
    vlp_run = 0;
    rd_chk(32'h008, "R8 not sticky");

    // R2 erase handshake
    mass_erase_en = 1;
    pulse_start();
    rd_chk(32'h028, "R2 start without launch");
    pulse_launch();
    rd_chk(32'h028, "R2 pending before start");
    pulse_start();
    rd_chk(32'h029, "R2 ack after start");
    pulse_launch();
    rd_chk(32'h028, "R1 launch clears ack");
    pulse_start();
    rd_chk(32'h029, "R2 ack again");
    pulse_sysrst();
    rd_chk(32'h028, "R1 system reset clears ack");
    pulse_start();
    rd_chk(32'h028, "R2 no ack after reset dropped pending");

    // R3 disabled erase
    mass_erase_en = 0;
    pulse_launch();
    mass_erase_en = 1;
    pulse_start();
    rd_chk(32'h028, "R3 disabled launch not acknowledged");
    mass_erase_en = 0;

    // R9 / R10 sticky exit flag
    @(negedge clk) lls_exit = 1;
    @(negedge clk) lls_exit = 0;
    rd_chk(32'h208, "R9 set by exit");
    rd_chk(32'h208, "R9 stays set");
    @(negedge clk) exit_clr_wr = 1;
    @(negedge clk) exit_clr_wr = 0;
    rd_chk(32'h008, "R10 write-1 clears");
    @(negedge clk) begin lls_exit = 1; exit_clr_wr = 1; end
    @(negedge clk) begin lls_exit = 0; exit_clr_wr = 0; end
    rd_chk(32'h208, "R10 exit wins over clear");
    pulse_sysrst();
    rd_chk(32'h008, "R10 system reset clears");

    // R11 upper bits with all live inputs high
    {flash_ready, secure_lock, backdoor_en, vlp_run} = 4'hF;
    stop_mode_sel = 3'b011;
    rd_chk(32'h1CE, "R11 reserved zero all high");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule